// File: doc/BRIEF.md
# Operand Bypass Forwarding Network

This block supplies the two ALU operands of a five-stage integer pipeline. It sits at the end of the decode stage. For each of the two source registers named by the instruction in decode, it compares the register number with the destinations of the instructions now in execute and in memory access. It then picks one of three values: the register-file read port, the live ALU result from execute, or the live access-stage result. The access-stage result is either load data or an ALU result passed along, so every result writes back in one stage through a single write port.

The selected values are captured in flip-flops, and those flops drive the ALU inputs directly in the next cycle. The ALU therefore sees only one multiplexer and one register ahead of it, with no register-file read in its path. When several stages hold a matching result, the youngest one wins: execute beats access, and access beats the register file. Register zero and stages that do not write are never forwarded from. A stall input freezes both operand registers.

Top module: `opnd_bypass_net`

## Requirements
- R1: While reset is asserted (synchronous, active low), both operand outputs are cleared to zero on the next clock edge.
- R2: When neither execute nor access holds a matching write, an operand output takes the register-file read value presented in the previous cycle.
- R3: When execute has its write-enable set, a non-zero destination and a destination equal to the operand's source, the operand output takes the execute-stage data of the previous cycle.
- R4: When only access has its write-enable set, a non-zero destination and a destination equal to the source, the operand output takes the access-stage data of the previous cycle.
- R5: When execute and access both match the same source, the execute-stage data is taken.
- R6: A stage whose write-enable is low is never selected, even if its destination equals the source.
- R7: A destination of register 0 is never forwarded; a source of 0 always takes the register-file value.
- R8: While stall is high, both operand outputs keep their values, whatever the other inputs do.
- R9: Operand A and operand B select independently; each may take a different source in the same cycle.
- R10: Every selection shows at the outputs exactly one clock after its inputs, so back-to-back dependent instructions get the right value every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Holds both operand registers |
| dec_src_a_i | input | AW (5) | Source register number of operand A in decode |
| dec_src_b_i | input | AW (5) | Source register number of operand B in decode |
| rf_a_i | input | DW (32) | Register-file read data for operand A |
| rf_b_i | input | DW (32) | Register-file read data for operand B |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_dst_i | input | AW (5) | Execute-stage destination register number |
| ex_data_i | input | DW (32) | Live ALU output in execute |
| acc_wen_i | input | 1 | Access-stage instruction writes a register |
| acc_dst_i | input | AW (5) | Access-stage destination register number |
| acc_data_i | input | DW (32) | Live access-stage output (load data or passed ALU result) |
| opnd_a_o | output | DW (32) | Registered ALU operand A |
| opnd_b_o | output | DW (32) | Registered ALU operand B |

## Verification
Every data source carries its own distinct value, so each operand check shows which of the three inputs was picked. The tests cover no-hazard reads, a lone execute match, a lone access match, and a match on both stages. These separate the three mux legs and the priority order. Near-miss patterns check that no false forward occurs: a matching register with write-enable low, a register 0 destination, and operand A and B hitting different stages. A subtract feeding two later instructions, with checks each cycle, followed by a stall with all inputs changed, checks the one-cycle timing and the hold.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;

    // Which producer feeds an operand
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_ACC = 2'd2
    } opsrc_e;

endpackage

// File: rtl/byp_select.sv
module byp_select
    import opbyp_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic          ex_wen_i,
    input  logic [AW-1:0] ex_dst_i,
    input  logic          acc_wen_i,
    input  logic [AW-1:0] acc_dst_i,
    output opsrc_e        sel_o
);

    logic hit_ex;
    logic hit_acc;

    // A producer qualifies only if it writes, targets a real register and matches
    always_comb begin
        hit_ex  = ex_wen_i  && (ex_dst_i  != '0) && (ex_dst_i  == src_i);
        hit_acc = acc_wen_i && (acc_dst_i != '0) && (acc_dst_i == src_i);
    end

    // Youngest producer wins
    always_comb begin
        if (hit_ex) begin
            sel_o = SRC_EX;
        end else if (hit_acc) begin
            sel_o = SRC_ACC;
        end else begin
            sel_o = SRC_RF;
        end
    end

endmodule

// File: rtl/byp_mux.sv
module byp_mux
    import opbyp_pkg::*;
#(
    parameter int DW = 32
) (
    input  opsrc_e        sel_i,
    input  logic [DW-1:0] rf_i,
    input  logic [DW-1:0] ex_i,
    input  logic [DW-1:0] acc_i,
    output logic [DW-1:0] data_o
);

    always_comb begin
        unique case (sel_i)
            SRC_EX:  data_o = ex_i;
            SRC_ACC: data_o = acc_i;
            default: data_o = rf_i;
        endcase
    end

endmodule

// File: rtl/opnd_bypass_net.sv
module opnd_bypass_net
    import opbyp_pkg::*;
#(
    parameter int DW   = 32,
    parameter int REGS = 32,
    parameter int AW   = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall_i,
    input  logic [AW-1:0] dec_src_a_i,
    input  logic [AW-1:0] dec_src_b_i,
    input  logic [DW-1:0] rf_a_i,
    input  logic [DW-1:0] rf_b_i,
    input  logic          ex_wen_i,
    input  logic [AW-1:0] ex_dst_i,
    input  logic [DW-1:0] ex_data_i,
    input  logic          acc_wen_i,
    input  logic [AW-1:0] acc_dst_i,
    input  logic [DW-1:0] acc_data_i,
    output logic [DW-1:0] opnd_a_o,
    output logic [DW-1:0] opnd_b_o
);

    localparam int NOPS = 2;

    typedef struct packed {
        logic [NOPS-1:0][DW-1:0] opnd;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NOPS-1:0][AW-1:0] src;
    logic [NOPS-1:0][DW-1:0] rf_rd;
    logic [NOPS-1:0][DW-1:0] picked;
    opsrc_e                  sel [NOPS];

    always_comb begin
        src[0]   = dec_src_a_i;
        src[1]   = dec_src_b_i;
        rf_rd[0] = rf_a_i;
        rf_rd[1] = rf_b_i;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        byp_select #(.AW(AW)) u_sel (
            .src_i     (src[g]),
            .ex_wen_i  (ex_wen_i),
            .ex_dst_i  (ex_dst_i),
            .acc_wen_i (acc_wen_i),
            .acc_dst_i (acc_dst_i),
            .sel_o     (sel[g])
        );

        byp_mux #(.DW(DW)) u_mux (
            .sel_i  (sel[g]),
            .rf_i   (rf_rd[g]),
            .ex_i   (ex_data_i),
            .acc_i  (acc_data_i),
            .data_o (picked[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (!stall_i) begin
            state_d.opnd = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign opnd_a_o = state_q.opnd[0];
    assign opnd_b_o = state_q.opnd[1];

endmodule

// File: rtl/opbyp_checker.sv
module opbyp_checker #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall_i,
    input logic [AW-1:0] dec_src_a_i,
    input logic [AW-1:0] dec_src_b_i,
    input logic [DW-1:0] rf_a_i,
    input logic [DW-1:0] rf_b_i,
    input logic          ex_wen_i,
    input logic [AW-1:0] ex_dst_i,
    input logic [DW-1:0] ex_data_i,
    input logic          acc_wen_i,
    input logic [AW-1:0] acc_dst_i,
    input logic [DW-1:0] acc_data_i,
    input logic [DW-1:0] opnd_a_o,
    input logic [DW-1:0] opnd_b_o
);

    logic ex_hit_a, acc_hit_a, ex_hit_b, acc_hit_b;
    assign ex_hit_a  = ex_wen_i  && ex_dst_i  != '0 && ex_dst_i  == dec_src_a_i;
    assign acc_hit_a = acc_wen_i && acc_dst_i != '0 && acc_dst_i == dec_src_a_i;
    assign ex_hit_b  = ex_wen_i  && ex_dst_i  != '0 && ex_dst_i  == dec_src_b_i;
    assign acc_hit_b = acc_wen_i && acc_dst_i != '0 && acc_dst_i == dec_src_b_i;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (opnd_a_o == '0 && opnd_b_o == '0));

    a_r2_rf_path_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !ex_hit_a && !acc_hit_a) |=> opnd_a_o == $past(rf_a_i));

    a_r3_ex_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && ex_hit_a) |=> opnd_a_o == $past(ex_data_i));

    a_r4_acc_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !ex_hit_a && acc_hit_a) |=> opnd_a_o == $past(acc_data_i));

    a_r9_ex_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && ex_hit_b) |=> opnd_b_o == $past(ex_data_i));

    a_r9_acc_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !ex_hit_b && acc_hit_b) |=> opnd_b_o == $past(acc_data_i));

    a_r7_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && dec_src_a_i == '0) |=> opnd_a_o == $past(rf_a_i));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(opnd_a_o) && $stable(opnd_b_o)));

endmodule

bind opnd_bypass_net opbyp_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .dec_src_a_i (dec_src_a_i),
    .dec_src_b_i (dec_src_b_i),
    .rf_a_i      (rf_a_i),
    .rf_b_i      (rf_b_i),
    .ex_wen_i    (ex_wen_i),
    .ex_dst_i    (ex_dst_i),
    .ex_data_i   (ex_data_i),
    .acc_wen_i   (acc_wen_i),
    .acc_dst_i   (acc_dst_i),
    .acc_data_i  (acc_data_i),
    .opnd_a_o    (opnd_a_o),
    .opnd_b_o    (opnd_b_o)
);

// File: tb/opnd_bypass_net_bench.sv
`timescale 1ns/1ps
module opnd_bypass_net_bench;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stall_i;
    logic [AW-1:0] dec_src_a_i, dec_src_b_i, ex_dst_i, acc_dst_i;
    logic [DW-1:0] rf_a_i, rf_b_i, ex_data_i, acc_data_i;
    logic          ex_wen_i, acc_wen_i;
    logic [DW-1:0] opnd_a_o, opnd_b_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    opnd_bypass_net u_opnd_bypass_net (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .dec_src_a_i(dec_src_a_i), .dec_src_b_i(dec_src_b_i),
        .rf_a_i(rf_a_i), .rf_b_i(rf_b_i),
        .ex_wen_i(ex_wen_i), .ex_dst_i(ex_dst_i), .ex_data_i(ex_data_i),
        .acc_wen_i(acc_wen_i), .acc_dst_i(acc_dst_i), .acc_data_i(acc_data_i),
        .opnd_a_o(opnd_a_o), .opnd_b_o(opnd_b_o)
    );

    // Fixed, distinct data on every source so the picked leg is visible
    localparam logic [DW-1:0] RF_A = 32'hAAAA_0001;
    localparam logic [DW-1:0] RF_B = 32'hBBBB_0002;
    localparam logic [DW-1:0] EXD  = 32'hEEEE_0003;
    localparam logic [DW-1:0] ACD  = 32'hCCCC_0004;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [AW-1:0] sa, logic [AW-1:0] sb,
                         logic ew, logic [AW-1:0] ed,
                         logic aw, logic [AW-1:0] ad);
        dec_src_a_i = sa; dec_src_b_i = sb;
        ex_wen_i = ew;  ex_dst_i = ed;
        acc_wen_i = aw; acc_dst_i = ad;
        rf_a_i = RF_A; rf_b_i = RF_B; ex_data_i = EXD; acc_data_i = ACD;
    endtask

    // Inputs change at negedge; one posedge registers; sample at following negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stall_i = 1'b0;
        drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b0, 5'd0);
        tick(); tick();
        chk("R1 reset A", opnd_a_o, '0);
        chk("R1 reset B", opnd_b_o, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_rf_only();
        drive(5'd5, 5'd6, 1'b1, 5'd7, 1'b1, 5'd8);
        tick();
        chk("R2 rf A", opnd_a_o, RF_A);
        chk("R2 rf B", opnd_b_o, RF_B);
    endtask

    task automatic t_ex_fwd();
        drive(5'd10, 5'd11, 1'b1, 5'd10, 1'b0, 5'd0);
        tick();
        chk("R3 ex A", opnd_a_o, EXD);
        chk("R9 B unaffected", opnd_b_o, RF_B);
    endtask

    task automatic t_acc_fwd();
        drive(5'd12, 5'd13, 1'b1, 5'd3, 1'b1, 5'd12);
        tick();
        chk("R4 acc A", opnd_a_o, ACD);
        chk("R4 rf B", opnd_b_o, RF_B);
    endtask

    task automatic t_priority();
        drive(5'd14, 5'd14, 1'b1, 5'd14, 1'b1, 5'd14);
        tick();
        chk("R5 both A", opnd_a_o, EXD);
        chk("R5 both B", opnd_b_o, EXD);
    endtask

    task automatic t_wen_low();
        drive(5'd15, 5'd16, 1'b0, 5'd15, 1'b0, 5'd16);
        tick();
        chk("R6 ex wen low", opnd_a_o, RF_A);
        chk("R6 acc wen low", opnd_b_o, RF_B);
        drive(5'd15, 5'd15, 1'b0, 5'd15, 1'b1, 5'd15);
        tick();
        chk("R6 falls to acc", opnd_a_o, ACD);
    endtask

    task automatic t_zero();
        drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        tick();
        chk("R7 zero A", opnd_a_o, RF_A);
        chk("R7 zero B", opnd_b_o, RF_B);
    endtask

    task automatic t_split();
        drive(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
        tick();
        chk("R9 A from ex", opnd_a_o, EXD);
        chk("R9 B from acc", opnd_b_o, ACD);
    endtask

    // sub r4,r3->r10 ; and r10,#3->r11 ; or r11,r10->r12
    task automatic t_chain();
        drive(5'd10, 5'd9, 1'b1, 5'd10, 1'b0, 5'd0);   // AND in decode, SUB in EX
        tick();
        chk("R10 and gets sub", opnd_a_o, EXD);
        drive(5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 5'd10); // OR in decode: AND in EX, SUB in ACC
        tick();
        chk("R10 or A from and", opnd_a_o, EXD);
        chk("R10 or B from sub", opnd_b_o, ACD);
        drive(5'd10, 5'd11, 1'b1, 5'd12, 1'b1, 5'd11); // next: OR in EX, AND in ACC
        tick();
        chk("R10 r10 now rf", opnd_a_o, RF_A);
        chk("R10 r11 from acc", opnd_b_o, ACD);
    endtask

    task automatic t_stall();
        drive(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
        tick();
        stall_i = 1'b1;
        drive(5'd1, 5'd2, 1'b0, 5'd0, 1'b0, 5'd0);
        rf_a_i = 32'h1234_5678; rf_b_i = 32'h8765_4321;
        tick(); tick();
        chk("R8 hold A", opnd_a_o, EXD);
        chk("R8 hold B", opnd_b_o, ACD);
        stall_i = 1'b0;
        tick();
        chk("R8 release A", opnd_a_o, 32'h1234_5678);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rf_only();
        t_ex_fwd();
        t_acc_fwd();
        t_priority();
        t_wen_low();
        t_zero();
        t_split();
        t_chain();
        t_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule